// File: doc/BRIEF.md
# Variable-Latency Register Slave with Wait Handshake

This block is a memory-mapped slave that makes a bus master wait for as long as a slow back-end takes to serve each access. The master selects the slave with an active-low chip select and one active-low strobe, either read or write. It also drives an address and, for a write, write data. The slave answers with read data and a wait flag.

The wait flag rises in the very cycle the access begins, with no register in the path. The master keeps every signal steady while the flag is high. The flag drops once a one-clock completion pulse from the back-end has arrived. This release does not depend on the chip select going inactive, because a stalled master keeps it asserted.

An internal latency model plays the part of the back-end. It produces the completion pulse after a number of cycles taken from a 4-bit delay input, sampled when the access starts. Storage is a small bank of 32-bit registers.

Each access ends in the first cycle where an access is presented and the wait flag is low. That is the completion cycle. Between two accesses the master leaves at least one cycle in which no access is presented.

Top module: `mms_wait_slave`

## Requirements
- R1: While no access is presented (chip select high, or both strobes high), the wait flag is low.
- R2: When an access is presented after an idle cycle and the delay input is nonzero, the wait flag is high in that same cycle, before any clock edge.
- R3: An access with delay D in the range 0 to 15 holds the wait flag high for exactly D rising clock edges. The delay is sampled in the first cycle of the access. Changes to the delay input later in the same access have no effect on its length.
- R4: With a delay of 0, the wait flag stays low for the whole access, and the access completes in its first cycle.
- R5: While the active-low reset is low, the wait flag is low. Reset clears every register to 0.
- R6: A write stores the write data into the register whose index equals the 2-bit address value (0 to 3). It does so once, at the clock edge that ends the completion cycle. The other registers are left unchanged.
- R7: In the completion cycle of a read, the read data equals the last value written to the addressed register, or 0 if that register has not been written since reset.
- R8: Accesses separated by a single idle cycle each stall for their full programmed delay. No access is released early by the previous completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| sel_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register index |
| wdata_i | input | 32 | Write data |
| delay_i | input | 4 | Back-end latency in cycles, sampled at access start |
| rdata_o | output | 32 | Read data of the addressed register |
| wait_o | output | 1 | Wait request: master must hold its signals while high |

## Verification
The assertions take several things for granted about the master. It holds the access presented for as long as the wait flag is high. It never asserts both strobes together. It leaves an idle cycle between accesses, so every access start is seen as a rise of the access term. The bench drives every input at the falling clock edge. It keeps chip select, strobe, address and data fixed from the start of an access until one edge after the wait flag has been seen low, and then releases the access for exactly one cycle. Only the delay input is changed mid-access, and only in the dedicated case for R3, since that is the single input the slave must ignore during an access.

// File: rtl/mms_pkg.sv
package mms_pkg;
  localparam int unsigned MMS_DATA_W = 32;
  localparam int unsigned MMS_NREGS  = 4;
  localparam int unsigned MMS_DLY_W  = 4;
  localparam int unsigned MMS_ADDR_W = $clog2(MMS_NREGS);

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/mms_latency_model.sv
module mms_latency_model #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             access_i,
  input  logic             done_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             pulse_o
);
  logic             busy_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] lat_q;
  logic [DLY_W-1:0] target;

  // First cycle uses the live delay; later cycles use the latched copy.
  assign target  = busy_q ? lat_q : delay_i;
  assign pulse_o = access_i & ~done_i & (cnt_q == target);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lat_q  <= '0;
    end else if (!access_i || pulse_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!done_i) begin
      if (!busy_q) begin
        busy_q <= 1'b1;
        lat_q  <= delay_i;
        cnt_q  <= DLY_W'(1);
      end else begin
        cnt_q  <= cnt_q + DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/mms_wait_ctrl.sv
module mms_wait_ctrl (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic access_i,
  input  logic pulse_i,
  output logic done_o,
  output logic wait_o,
  output logic commit_o
);
  logic done_q;

  // Done flag: set by the completion pulse, cleared once the access is gone.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)       done_q <= 1'b0;
    else if (!access_i) done_q <= 1'b0;
    else if (pulse_i)   done_q <= 1'b1;
  end

  assign done_o   = done_q;
  assign wait_o   = rst_n_i & access_i & ~done_q & ~pulse_i;
  assign commit_o = rst_n_i & pulse_i;
endmodule

// File: rtl/mms_reg_bank.sv
module mms_reg_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                                 regs[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g)))      regs[g] <= wdata_i;
    end
  end

  assign rdata_o = regs[addr_i];
endmodule

// File: rtl/mms_wait_slave.sv
module mms_wait_slave
  import mms_pkg::*;
#(
  parameter int unsigned DATA_W = MMS_DATA_W,
  parameter int unsigned NREGS  = MMS_NREGS,
  parameter int unsigned DLY_W  = MMS_DLY_W,
  localparam int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              sel_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_o
);
  acc_kind_e kind;
  logic      access_w;
  logic      pulse_w;
  logic      done_w;
  logic      commit_w;
  logic      wr_commit_w;

  always_comb begin
    if (sel_n_i)      kind = ACC_NONE;
    else if (!wr_n_i) kind = ACC_WRITE;
    else if (!rd_n_i) kind = ACC_READ;
    else              kind = ACC_NONE;
  end

  assign access_w    = (kind != ACC_NONE);
  assign wr_commit_w = commit_w & (kind == ACC_WRITE);

  mms_latency_model #(.DLY_W(DLY_W)) lat_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .access_i(access_w),
    .done_i  (done_w),
    .delay_i (delay_i),
    .pulse_o (pulse_w)
  );

  mms_wait_ctrl ctrl_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .access_i(access_w),
    .pulse_i (pulse_w),
    .done_o  (done_w),
    .wait_o  (wait_o),
    .commit_o(commit_w)
  );

  mms_reg_bank #(.DATA_W(DATA_W), .NREGS(NREGS)) bank_i (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .we_i   (wr_commit_w),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );
endmodule

module mms_wait_slave_chk #(
  parameter int unsigned DLY_W = 4
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             access_w,
  input logic             wr_commit_w,
  input logic [DLY_W-1:0] delay_i,
  input logic             wait_o
);
  logic       act_prev_q;
  logic [4:0] stall_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      act_prev_q <= 1'b0;
      stall_q    <= '0;
    end else begin
      act_prev_q <= access_w;
      if (!access_w)   stall_q <= '0;
      else if (wait_o) stall_q <= stall_q + 5'd1;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !access_w |-> !wait_o);
  // R2
  start_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (access_w && !act_prev_q && (delay_i != '0)) |-> wait_o);
  // R3
  stall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wait_o |-> (stall_q < 5'd15));
  // R4
  zero_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (access_w && !act_prev_q && (delay_i == '0)) |-> !wait_o);
  // R5
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_n_i |-> !wait_o);
  // R6
  single_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_commit_w |=> !wr_commit_w);
  // R8
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (access_w && !wait_o) |=> (!access_w || !wait_o));
endmodule

bind mms_wait_slave mms_wait_slave_chk #(.DLY_W(DLY_W)) chk_i (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .access_w   (access_w),
  .wr_commit_w(wr_commit_w),
  .delay_i    (delay_i),
  .wait_o     (wait_o)
);

// File: tb/mms_wait_slave_tb_top.sv
`timescale 1ns/1ps
module mms_wait_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  delay = '0;
  logic [31:0] rdata;
  logic        wt;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [4];

  always #2.5 clk = ~clk;

  mms_wait_slave dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .sel_n_i(sel_n), .rd_n_i(rd_n),
    .wr_n_i(wr_n), .addr_i(addr), .wdata_i(wdata), .delay_i(delay),
    .rdata_o(rdata), .wait_o(wt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One access; returns wait seen at start, stall edges and completion data.
  task automatic access(input bit is_wr, input logic [1:0] a,
                        input logic [31:0] wd, input int d, input bit mid_change,
                        output bit start_wt, output int stalls,
                        output logic [31:0] rd);
    @(negedge clk);
    delay = 4'(d);
    sel_n = 1'b0; addr = a; wdata = wd;
    rd_n = is_wr; wr_n = !is_wr;
    #1;
    start_wt = wt;
    stalls = 0;
    while (wt && stalls < 40) begin
      @(negedge clk);
      if (mid_change) delay = 4'(15 - d);
      #1;
      stalls++;
    end
    rd = rdata;
    @(negedge clk);
    sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit          sw;
    int          st;
    logic [31:0] rv;
    for (int i = 0; i < 4; i++) model[i] = '0;

    // R5: reset holds wait low even with an access presented
    sel_n = 1'b0; rd_n = 1'b0; delay = 4'd5;
    repeat (3) @(negedge clk);
    #1;
    chk(wt == 1'b0, "R5", "wait in reset", wt, 0);
    sel_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle
    chk(wt == 1'b0, "R1", "wait idle sel high", wt, 0);
    sel_n = 1'b0; #1;
    chk(wt == 1'b0, "R1", "wait sel low no strobe", wt, 0);
    sel_n = 1'b1;

    // R5: registers zero after reset
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 2'(i), '0, 1, 1'b0, sw, st, rv);
      chk(rv == 32'h0, "R5", "reg after reset", rv, 0);
    end

    // Sweep all delays, write then read back-to-back
    for (int d = 0; d < 16; d++) begin
      logic [31:0] v;
      v = 32'h5A000000 ^ (32'(d) * 32'h01030507);
      access(1'b1, 2'(d % 4), v, d, 1'b0, sw, st, rv);
      model[d % 4] = v;
      if (d == 0) chk(sw == 1'b0, "R4", "wait at start delay0", sw, 0);
      else        chk(sw == 1'b1, "R2", "wait at start", sw, 1);
      chk(st == d, "R3", "write stall edges", st, d);
      access(1'b0, 2'(d % 4), 32'hFFFF_FFFF, d, 1'b0, sw, st, rv);
      chk(st == d, "R8", "back-to-back read stall", st, d);
      chk(rv == v, "R7", "read after write", rv, v);
    end

    // R6: each register holds its last write only
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 2'(i), '0, 0, 1'b0, sw, st, rv);
      chk(rv == model[i], "R6", "register isolation", rv, model[i]);
    end

    // R3: delay changed mid-access is ignored
    for (int d = 2; d < 14; d += 5) begin
      access(1'b0, 2'd1, '0, d, 1'b1, sw, st, rv);
      chk(st == d, "R3", "mid-access delay change", st, d);
      chk(rv == model[1], "R7", "read with changed delay", rv, model[1]);
    end

    @(negedge clk); #1;
    chk(wt == 1'b0, "R1", "wait idle at end", wt, 0);
    summary();
  end
endmodule